// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a 16-bit interval timer that software drives through three word registers: a control/status word, a preset (count-set) buffer and a free-readable counter. Software first writes a preset value, which also loads the counter. It then writes the control word to pick the direction, the mode, the tick source and interrupt enabling, and to start counting. While running, each pulse on the selected tick enable moves the counter by one step, up or down.

When the counter steps past its end (below zero counting down, above all-ones counting up), the block reaches terminal count. It raises a done flag and, if interrupts are enabled, an interrupt request that stays high until the acknowledge input is pulsed. In single mode the timer then stops and clears the counter. In repeat mode it reloads from the preset buffer and keeps going, so it produces a steady train of requests. A terminal count that arrives while the previous request is still unacknowledged sets a sticky error flag. A maintenance bit lets software apply exactly one count step while the timer is stopped.

Top module: `ivt_top`

## Requirements
- R1: After reset the control word, the preset buffer, the counter and `irq_req` all read 0.
- R2: A write at byte offset 2 stores all 16 bits in the preset buffer and loads the same value into the counter. Offset 2 reads back the buffer and offset 4 reads the counter. A write at offset 4 has no effect on the counter.
- R3: Control word layout: bit 0 RUN, bits 2:1 tick select (counting uses `tick_en[select]`), bit 3 mode (1 = repeat), bit 4 direction (1 = up), bit 5 single-step (always reads 0), bit 6 interrupt enable, bit 7 DONE, bit 15 ERR. All other bits read 0. Pulses on tick inputs that are not selected are ignored.
- R4: While RUN is set, each cycle with the selected tick high and no terminal condition adds 1 to the counter, or subtracts 1 when counting down.
- R5: Terminal count is a counting step taken while the counter holds 0 (counting down) or 0xFFFF (counting up).
- R6: In single mode, terminal count sets DONE, clears RUN and sets the counter to 0. After that, ticks no longer change the counter.
- R7: In repeat mode, terminal count sets DONE, reloads the counter from the preset buffer, and leaves RUN set.
- R8: A terminal count with interrupts enabled sets `irq_req`. It stays high until a one-cycle `irq_ack` pulse. With interrupts disabled, no request is raised.
- R9: In repeat mode, a terminal count while `irq_req` is still high sets ERR. ERR stays set through later acknowledges.
- R10: Any write to the control word clears DONE and ERR.
- R11: A control write with the single-step bit set and RUN clear applies exactly one counting step, in the written direction, in the cycle after the write. That step uses the normal terminal handling. With RUN set in the same write, no step is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 4 | One-cycle count enables, one per selectable rate |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte offset: 0 control, 2 preset, 4 counter |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| irq_req | output | 1 | Interrupt request, held until acknowledged |
| irq_ack | input | 1 | Interrupt acknowledge pulse |

## Verification
The first stimulus is a single-mode down count from a preset of 60. The bench checks that 60 ticks reach zero with nothing raised and that the 61st tick stops the timer. This separates the terminal-on-zero rule from an off-by-one "terminal on reaching zero" design. Three repeat-mode periods on a different tick source show reload and continued running, and separate per-period acknowledge from a one-shot design. A period left unacknowledged must set ERR, and an acknowledged one must not. An up count from 0xFFFD tests the all-ones wrap. Runs with interrupts disabled, with ticks on unselected inputs and with single-step writes show the inputs that must have no effect.

// File: rtl/ivt_pkg.sv
// Package: shared field positions and types for the interval timer.
// Assumes a data word of at least 16 bits so the error flag position exists.
package ivt_pkg;
    localparam int unsigned NUM_RATES   = 4;
    localparam int unsigned RATE_W      = $clog2(NUM_RATES);
    localparam int unsigned CTL_RUN     = 0;
    localparam int unsigned CTL_RATE_LO = 1;
    localparam int unsigned CTL_MODE    = 3;
    localparam int unsigned CTL_UP      = 4;
    localparam int unsigned CTL_STEP    = 5;
    localparam int unsigned CTL_IE      = 6;
    localparam int unsigned CTL_DONE    = 7;
    localparam int unsigned CTL_ERR     = 15;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_REPEAT = 1'b1
    } run_mode_e;

    typedef struct packed {
        logic              run;
        logic [RATE_W-1:0] rate;
        run_mode_e         mode;
        logic              up;
        logic              ie;
    } ctl_t;
endpackage

// File: rtl/ivt_regs.sv
// Register file: control word, preset buffer, single-step pulse and read mux.
// Assumes byte offsets 0/2/4 on an ADDR_W-bit address and DATA_W >= 16.
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tc,
    input  logic              err,
    input  logic [DATA_W-1:0] cnt,
    output ctl_t              ctl,
    output logic              done,
    output logic [DATA_W-1:0] preset,
    output logic              load,
    output logic              ctl_wr,
    output logic              step_pulse,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] OFF_CTL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_PRE = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFF_CNT = ADDR_W'(4);

    logic [DATA_W-1:0] status_word;

    // Write decode for the two writable registers.
    assign ctl_wr = wr_en && (addr == OFF_CTL);
    assign load   = wr_en && (addr == OFF_PRE);

    // Control fields: written by software, RUN cleared by a single-mode terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (ctl_wr) begin
            ctl.run  <= wdata[CTL_RUN];
            ctl.rate <= wdata[CTL_RATE_LO +: RATE_W];
            ctl.mode <= run_mode_e'(wdata[CTL_MODE]);
            ctl.up   <= wdata[CTL_UP];
            ctl.ie   <= wdata[CTL_IE];
        end else if (tc && ctl.mode == MODE_SINGLE) begin
            ctl.run <= 1'b0;
        end
    end

    // DONE: set by terminal count, cleared by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       done <= 1'b0;
        else if (tc)      done <= 1'b1;
        else if (ctl_wr)  done <= 1'b0;
    end

    // Preset buffer holds the reload value.
    always_ff @(posedge clk) begin
        if (!rst_n)    preset <= '0;
        else if (load) preset <= wdata;
    end

    // Single-step request: one cycle after a control write with step set and RUN clear.
    always_ff @(posedge clk) begin
        if (!rst_n) step_pulse <= 1'b0;
        else        step_pulse <= ctl_wr && wdata[CTL_STEP] && !wdata[CTL_RUN];
    end

    // Assemble the status word; unused bits read 0.
    always_comb begin
        status_word                          = '0;
        status_word[CTL_RUN]                 = ctl.run;
        status_word[CTL_RATE_LO +: RATE_W]   = ctl.rate;
        status_word[CTL_MODE]                = ctl.mode;
        status_word[CTL_UP]                  = ctl.up;
        status_word[CTL_IE]                  = ctl.ie;
        status_word[CTL_DONE]                = done;
        status_word[CTL_ERR]                 = err;
    end

    // Read mux by offset.
    always_comb begin
        case (addr)
            OFF_CTL: rdata = status_word;
            OFF_PRE: rdata = preset;
            OFF_CNT: rdata = cnt;
            default: rdata = '0;
        endcase
    end

    a_r6_run_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && ctl.mode == MODE_SINGLE && !ctl_wr) |=> !ctl.run);
    a_r10_done_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !tc) |=> !done);
    a_r11_step_once: assert property (@(posedge clk) disable iff (!rst_n)
        (step_pulse && !ctl_wr) |=> !step_pulse);
endmodule

// File: rtl/ivt_count.sv
// Counter: steps on the selected tick or a single-step pulse, detects terminal
// count and applies stop-and-clear or reload. Assumes one step at most per cycle.
module ivt_count
    import ivt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RATES-1:0] tick_en,
    input  logic [RATE_W-1:0]    rate,
    input  logic                 run,
    input  logic                 up,
    input  run_mode_e            mode,
    input  logic                 step_pulse,
    input  logic                 load,
    input  logic [CNT_W-1:0]     load_val,
    input  logic [CNT_W-1:0]     preset,
    output logic [CNT_W-1:0]     cnt,
    output logic                 tc
);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
    localparam logic [CNT_W-1:0] ALL1   = {CNT_W{1'b1}};

    logic step;
    logic at_end;

    // A counting step comes from the selected tick while running, or a single step.
    assign step   = (run && tick_en[rate]) || step_pulse;
    assign at_end = up ? (cnt == ALL1) : (cnt == '0);
    assign tc     = step && at_end && !load;

    // Counter update: software load first, then terminal handling, then a plain step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tc) begin
            cnt <= (mode == MODE_REPEAT) ? preset : '0;
        end else if (step) begin
            cnt <= up ? cnt + ONE : cnt - ONE;
        end
    end

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));
    a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step && up && !at_end && !load) |=> cnt == $past(cnt) + ONE);
    a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !up && !at_end && !load) |=> cnt == $past(cnt) - ONE);
    a_r6_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && mode == MODE_SINGLE) |=> cnt == '0);
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && mode == MODE_REPEAT) |=> cnt == $past(preset));
endmodule

// File: rtl/ivt_irq.sv
// Interrupt tracking: pending request held until acknowledge, sticky error on a
// repeat-mode terminal count that finds the previous request unserviced.
module ivt_irq
    import ivt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tc,
    input  logic      ie,
    input  run_mode_e mode,
    input  logic      ack,
    input  logic      clr,
    output logic      pending,
    output logic      err
);
    // Request: set by an enabled terminal count, dropped by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)        pending <= 1'b0;
        else if (tc && ie) pending <= 1'b1;
        else if (ack)      pending <= 1'b0;
    end

    // Error: set on overrun in repeat mode, cleared only by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          err <= 1'b0;
        else if (tc && mode == MODE_REPEAT && pending && !ack) err <= 1'b1;
        else if (clr)                                        err <= 1'b0;
    end

    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && ie) |=> pending);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack) |=> pending);
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr) |=> err);
endmodule

// File: rtl/ivt_top.sv
// Interval timer top: ties the register file, counter and interrupt tracker.
// Assumes tick enables are synchronous one-cycle pulses in the clk domain.
module ivt_top
    import ivt_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RATES-1:0] tick_en,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq_req,
    input  logic                 irq_ack
);
    ctl_t              ctl;
    logic              done;
    logic [DATA_W-1:0] preset;
    logic [DATA_W-1:0] cnt;
    logic              load;
    logic              ctl_wr;
    logic              step_pulse;
    logic              tc;
    logic              err;

    ivt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .tc(tc), .err(err), .cnt(cnt), .ctl(ctl),
        .done(done), .preset(preset), .load(load), .ctl_wr(ctl_wr),
        .step_pulse(step_pulse), .rdata(reg_rdata)
    );

    ivt_count #(.CNT_W(DATA_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate(ctl.rate),
        .run(ctl.run), .up(ctl.up), .mode(ctl.mode), .step_pulse(step_pulse),
        .load(load), .load_val(reg_wdata), .preset(preset), .cnt(cnt), .tc(tc)
    );

    ivt_irq u_irq (
        .clk(clk), .rst_n(rst_n), .tc(tc), .ie(ctl.ie), .mode(ctl.mode),
        .ack(irq_ack), .clr(ctl_wr), .pending(irq_req), .err(err)
    );

    a_r9_err_needs_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ctl.mode == MODE_REPEAT);
    a_r5_tc_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> done);
endmodule

// File: tb/ivt_top_test.sv
`timescale 1ns/1ps
module ivt_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tick_en = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_req;
    logic        irq_ack = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        bit          is_irq;
        logic [2:0]  addr;
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    ivt_top uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_ack(irq_ack)
    );

    // Monitor: pops expected items and compares them away from the clock edge.
    initial begin
        forever begin
            wait (sb.size() > 0);
            @(negedge clk);
            reg_addr = sb[0].addr;
            #1;
            n_checks++;
            if (sb[0].is_irq) begin
                if (irq_req !== sb[0].exp[0]) begin
                    n_fail++;
                    $display("FAIL %s: irq_req actual %0b expected %0b", sb[0].tag, irq_req, sb[0].exp[0]);
                end
            end else if (reg_rdata !== sb[0].exp) begin
                n_fail++;
                $display("FAIL %s: offset %0d actual %h expected %h", sb[0].tag, sb[0].addr, reg_rdata, sb[0].exp);
            end
            void'(sb.pop_front());
        end
    end

    task automatic expect_reg(input logic [2:0] a, input logic [15:0] v, input string tag);
        item_t it;
        it.is_irq = 1'b0; it.addr = a; it.exp = v; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic expect_irq(input bit v, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.addr = 3'd0; it.exp = {15'd0, v}; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ticks(input int idx, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en[idx] = 1'b1;
            @(negedge clk);
            tick_en[idx] = 1'b0;
        end
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        #(5ns * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        expect_reg(3'd0, 16'h0000, "R1 ctrl");
        expect_reg(3'd2, 16'h0000, "R1 preset");
        expect_reg(3'd4, 16'h0000, "R1 counter");
        expect_irq(1'b0, "R1 irq");

        // R2 preset write loads counter; counter write ignored
        wr(3'd2, 16'd60);
        expect_reg(3'd2, 16'd60, "R2 preset");
        expect_reg(3'd4, 16'd60, "R2 counter load");
        wr(3'd4, 16'h1234);
        expect_reg(3'd4, 16'd60, "R2 counter write ignored");

        // R3 layout and unselected ticks; single mode down count of 60
        wr(3'd0, 16'h0041);
        expect_reg(3'd0, 16'h0041, "R3 ctrl readback");
        ticks(1, 3);
        expect_reg(3'd4, 16'd60, "R3 unselected tick");
        ticks(0, 60);
        expect_reg(3'd4, 16'd0, "R4 down to zero");
        expect_irq(1'b0, "R5 no terminal at zero");
        expect_reg(3'd0, 16'h0041, "R5 still running");
        ticks(0, 1);
        expect_reg(3'd0, 16'h00C0, "R6 done set run cleared");
        expect_reg(3'd4, 16'd0, "R6 counter cleared");
        expect_irq(1'b1, "R8 request raised");
        ticks(0, 2);
        expect_reg(3'd4, 16'd0, "R6 stopped");
        expect_irq(1'b1, "R8 request held");
        ack();
        expect_irq(1'b0, "R8 ack drops request");

        // R7 repeat mode, three periods on tick source 1
        wr(3'd2, 16'd4);
        wr(3'd0, 16'h004B);
        expect_reg(3'd0, 16'h004B, "R10 done cleared by write");
        for (int p = 0; p < 3; p++) begin
            ticks(1, 4);
            expect_reg(3'd4, 16'd0, "R4 repeat period at zero");
            expect_irq(1'b0, "R8 no early request");
            ticks(1, 1);
            expect_reg(3'd4, 16'd4, "R7 reload");
            expect_reg(3'd0, 16'h00CB, "R7 done and still running");
            expect_irq(1'b1, "R8 repeat request");
            ack();
            expect_irq(1'b0, "R8 repeat ack");
        end

        // R9 missed acknowledge
        ticks(1, 5);
        expect_irq(1'b1, "R9 first request");
        expect_reg(3'd0, 16'h00CB, "R9 no error yet");
        ticks(1, 5);
        expect_reg(3'd0, 16'h80CB, "R9 error set");
        ack();
        expect_reg(3'd0, 16'h80CB, "R9 error sticky");
        wr(3'd0, 16'h000A);
        expect_reg(3'd0, 16'h000A, "R10 write clears err and done");

        // R5 up-count overflow
        wr(3'd2, 16'hFFFD);
        wr(3'd0, 16'h0051);
        ticks(0, 2);
        expect_reg(3'd4, 16'hFFFF, "R4 up count");
        expect_irq(1'b0, "R5 no terminal at FFFF");
        ticks(0, 1);
        expect_reg(3'd4, 16'h0000, "R5 overflow clears");
        expect_reg(3'd0, 16'h00D0, "R5 overflow done");
        expect_irq(1'b1, "R8 overflow request");
        ack();

        // R8 interrupts disabled
        wr(3'd2, 16'd1);
        wr(3'd0, 16'h0001);
        ticks(0, 2);
        expect_reg(3'd0, 16'h0080, "R8 done without enable");
        expect_irq(1'b0, "R8 no request when disabled");

        // R11 single step
        wr(3'd2, 16'd5);
        wr(3'd0, 16'h0020);
        expect_reg(3'd4, 16'd4, "R11 one step down");
        expect_reg(3'd0, 16'h0000, "R11 step bit reads 0");
        wr(3'd0, 16'h0030);
        expect_reg(3'd4, 16'd5, "R11 one step up");
        wr(3'd2, 16'd0);
        wr(3'd0, 16'h0020);
        expect_reg(3'd0, 16'h0080, "R11 step terminal sets done");
        wr(3'd2, 16'd7);
        wr(3'd0, 16'h0021);
        expect_reg(3'd4, 16'd7, "R11 no step while running");
        wr(3'd0, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule